// File: doc/BRIEF.md
# I/O Strobe Decoder and ROM Overlay Mapper

This block sits beside an 8-bit processor bus in a home computer. It watches each I/O write and I/O read, along with the 16-bit port address and 8-bit data, and turns them into one-cycle strobes. The strobes go to three neighbours: the video gate array, a CRT controller and a parallel peripheral interface. Decoding is partial. Separate address bits act as independent active-low selects, so one access can reach more than one neighbour. Several strobes can then pulse in the same cycle.

The block holds the gate array's registers, which are written through commands coded in the top two data bits: the pen index, the colour value, the screen mode, the two ROM enables and a RAM configuration byte. From the ROM enables it builds per-quarter source selects for the four 16 KB memory quarters. When the matching ROM is enabled, reads of the lowest quarter come from the lower ROM and reads of the highest quarter come from the upper ROM. Writes always go to RAM. On I/O reads it steers the readable neighbours' data onto a return bus and fills with 0xFF when nothing readable is addressed.

Top module: `io_page_decoder`

## Requirements
- R1: An I/O write whose address bits 15:14 equal 01 produces a one-cycle `ga_we` pulse in the cycle after the write is sampled.
- R2: A gate-array write with data bits 7:6 = 00 loads data bits 4:0 into `pen` and pulses `pen_we`. Bit 5 is ignored.
- R3: A gate-array write with data bits 7:6 = 01 loads data bits 4:0 into `colour` and pulses `colour_we`.
- R4: A gate-array write with data bits 7:6 = 10 loads data bits 1:0 into `scr_mode`. Data bit 2 set clears `lrom_en`, and data bit 3 set clears `urom_en`.
- R5: A gate-array write with data bits 7:6 = 11 loads data bits 5:0 into `ram_cfg` and leaves `rd_src`, `pen`, `colour` and `scr_mode` unchanged.
- R6: Any I/O access with address bit 14 low addresses the CRT controller, with address bits 9:8 as the function. A write to 00 pulses `crtc_sel_we`, a write to 01 pulses `crtc_reg_we`, a read of 10 pulses `crtc_stat_re` and a read of 11 pulses `crtc_reg_re`.
- R7: A CRT controller write to function 10 or 11, or a read of function 00 or 01, pulses `crtc_illegal` and none of the four CRT controller strobes.
- R8: Any I/O access with address bit 11 low pulses `ppi_cs`, sets `ppi_port` to address bits 9:8 (00 A, 01 B, 10 C, 11 control), and pulses `ppi_we` on a write or `ppi_re` on a read.
- R9: `rd_src` carries a 2-bit code per quarter, with quarter q at bits 2q+1:2q. The codes are 00 RAM, 01 lower ROM and 10 upper ROM. Quarter 0 reads 01 when `lrom_en` is set, quarter 3 reads 10 when `urom_en` is set, and every other case is 00. `wr_src` is all zeros.
- R10: After reset, `pen`, `colour`, `scr_mode` and `ram_cfg` are zero, both ROM enables are set (`rd_src` = 0x81), and every strobe is low.
- R11: During an I/O read, `io_rdata` is combinational. It is `crtc_rdata` for a legal CRT controller read (function 10 or 11), `ppi_rdata` for a peripheral-interface read, the bitwise AND of the two when both are addressed, and 0xFF otherwise.
- R12: Strobes last one cycle per access, and independent selects may pulse together. For example, address 0x7400 written pulses `ga_we` and `ppi_we` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write cycle, one clock per access |
| io_rd | input | 1 | I/O read cycle, one clock per access |
| crtc_rdata | input | 8 | Data returned by the CRT controller |
| ppi_rdata | input | 8 | Data returned by the peripheral interface |
| io_rdata | output | 8 | Read data returned to the processor |
| ga_we | output | 1 | Gate-array access strobe |
| pen_we | output | 1 | Pen register written |
| colour_we | output | 1 | Colour register written |
| pen | output | 5 | Selected pen index |
| colour | output | 5 | Last colour value |
| scr_mode | output | 2 | Screen mode |
| lrom_en | output | 1 | Lower ROM overlay enabled |
| urom_en | output | 1 | Upper ROM overlay enabled |
| ram_cfg | output | 6 | RAM configuration byte |
| crtc_sel_we | output | 1 | CRT controller register-select write |
| crtc_reg_we | output | 1 | CRT controller register-data write |
| crtc_stat_re | output | 1 | CRT controller status read |
| crtc_reg_re | output | 1 | CRT controller register-data read |
| crtc_illegal | output | 1 | Illegal CRT controller access flagged |
| ppi_cs | output | 1 | Peripheral interface selected |
| ppi_port | output | 2 | Peripheral interface port index |
| ppi_we | output | 1 | Peripheral interface write |
| ppi_re | output | 1 | Peripheral interface read |
| rd_src | output | 8 | Per-quarter read source codes |
| wr_src | output | 8 | Per-quarter write source codes |

## Verification
The two collisions of interest come from the partial decode. A gate-array write can hit the peripheral interface at the same time, because address 0x7400 has bits 15:14 at 01 and bit 11 low. A CRT controller status read can hit a peripheral-interface port C read at the same time, because address 0x3600 has bits 14 and 11 both low. The bench drives both addresses. For the write, it expects `ga_we`, `ppi_we` and the correct register update together. For the read, it expects both read strobes and an `io_rdata` equal to the AND of two distinct neighbour values, 0xF0 & 0x3C = 0x30.

// File: rtl/io_page_pkg.sv
// Shared widths, field positions and codes for the I/O decoder.
// Assumes a 16-bit port address and an 8-bit data bus.
package io_page_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int NQ     = 4;     // memory quarters
    parameter int SRC_W  = 2;     // width of one source code
    parameter int CLR_W  = 5;     // pen / colour width
    parameter int CFG_W  = 6;     // RAM configuration width

    // Gate-array command coded in data bits 7:6
    typedef enum logic [1:0] {
        GA_PEN    = 2'b00,
        GA_COLOUR = 2'b01,
        GA_MODE   = 2'b10,
        GA_RAMCFG = 2'b11
    } ga_cmd_e;

    // Source codes for each memory quarter
    typedef enum logic [1:0] {
        SRC_RAM  = 2'b00,
        SRC_LROM = 2'b01,
        SRC_UROM = 2'b10
    } mem_src_e;
endpackage

// File: rtl/ga_regs.sv
// Gate-array register file. Decodes the command in data bits 7:6 on a
// gate-array write and updates pen, colour, mode, ROM enables and RAM config.
// Assumes hit is a one-cycle qualified write to the gate array.
module ga_regs
    import io_page_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              ga_we,
    output logic              pen_we,
    output logic              colour_we,
    output logic [CLR_W-1:0]  pen,
    output logic [CLR_W-1:0]  colour,
    output logic [1:0]        scr_mode,
    output logic              lrom_en,
    output logic              urom_en,
    output logic [CFG_W-1:0]  ram_cfg
);
    ga_cmd_e cmd;
    assign cmd = ga_cmd_e'(wdata[DATA_W-1 -: 2]);

    // Register the command strobes and update the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ga_we     <= 1'b0;
            pen_we    <= 1'b0;
            colour_we <= 1'b0;
            pen       <= '0;
            colour    <= '0;
            scr_mode  <= '0;
            lrom_en   <= 1'b1;
            urom_en   <= 1'b1;
            ram_cfg   <= '0;
        end else begin
            ga_we     <= hit;
            pen_we    <= hit && (cmd == GA_PEN);
            colour_we <= hit && (cmd == GA_COLOUR);
            if (hit) begin
                unique case (cmd)
                    GA_PEN:    pen    <= wdata[CLR_W-1:0];
                    GA_COLOUR: colour <= wdata[CLR_W-1:0];
                    GA_MODE: begin
                        scr_mode <= wdata[1:0];
                        lrom_en  <= !wdata[2];
                        urom_en  <= !wdata[3];
                    end
                    GA_RAMCFG: ram_cfg <= wdata[CFG_W-1:0];
                endcase
            end
        end
    end

    // R2
    pen_implies_ga_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_we |-> ga_we);

    // R5
    ramcfg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cfg != $past(ram_cfg)) |-> ($past(hit) && $past(wdata[7:6]) == 2'b11));

    // R4
    rom_en_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lrom_en) || $fell(urom_en)) |-> ($past(hit) && $past(wdata[7:6]) == 2'b10));
endmodule

// File: rtl/port_decode.sv
// Partial decoder for the CRT controller and peripheral interface.
// Address bit 14 low selects the CRT controller and bit 11 low selects the
// peripheral interface, both using bits 9:8 as function. Strobes are
// registered one-cycle pulses; read qualifiers are combinational.
// Assumes io_wr and io_rd are never high together.
module port_decode
    import io_page_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        crtc_n,     // address bit 14
    input  logic        ppi_n,      // address bit 11
    input  logic [1:0]  fn,         // address bits 9:8
    input  logic        io_wr,
    input  logic        io_rd,
    output logic        crtc_rd_ok,
    output logic        ppi_rd_hit,
    output logic        crtc_sel_we,
    output logic        crtc_reg_we,
    output logic        crtc_stat_re,
    output logic        crtc_reg_re,
    output logic        crtc_illegal,
    output logic        ppi_cs,
    output logic [1:0]  ppi_port,
    output logic        ppi_we,
    output logic        ppi_re
);
    logic crtc_hit, ppi_hit, crtc_wr_ok, crtc_bad;

    // Combinational select and legality decode
    always_comb begin
        crtc_hit   = !crtc_n && (io_wr || io_rd);
        ppi_hit    = !ppi_n && (io_wr || io_rd);
        crtc_wr_ok = !crtc_n && io_wr && !fn[1];
        crtc_rd_ok = !crtc_n && io_rd && fn[1];
        crtc_bad   = crtc_hit && !crtc_wr_ok && !crtc_rd_ok;
        ppi_rd_hit = !ppi_n && io_rd;
    end

    // Register the CRT controller strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crtc_sel_we  <= 1'b0;
            crtc_reg_we  <= 1'b0;
            crtc_stat_re <= 1'b0;
            crtc_reg_re  <= 1'b0;
            crtc_illegal <= 1'b0;
        end else begin
            crtc_sel_we  <= crtc_wr_ok && !fn[0];
            crtc_reg_we  <= crtc_wr_ok && fn[0];
            crtc_stat_re <= crtc_rd_ok && !fn[0];
            crtc_reg_re  <= crtc_rd_ok && fn[0];
            crtc_illegal <= crtc_bad;
        end
    end

    // Register the peripheral interface strobes and port index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppi_cs   <= 1'b0;
            ppi_port <= '0;
            ppi_we   <= 1'b0;
            ppi_re   <= 1'b0;
        end else begin
            ppi_cs <= ppi_hit;
            ppi_we <= ppi_hit && io_wr;
            ppi_re <= ppi_hit && io_rd;
            if (ppi_hit) ppi_port <= fn;
        end
    end

    // R6
    crtc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crtc_sel_we, crtc_reg_we, crtc_stat_re, crtc_reg_re, crtc_illegal}));

    // R7
    crtc_illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_illegal |-> $past(!crtc_n) && ($past(io_wr) ? $past(fn[1]) : !$past(fn[1])));

    // R8
    ppi_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppi_we || ppi_re) |-> ppi_cs);
endmodule

// File: rtl/mem_map.sv
// Per-quarter memory source selector. The lowest quarter reads the lower
// ROM and the highest the upper ROM when enabled; writes always go to RAM.
// Assumes NQ >= 2.
module mem_map
    import io_page_pkg::*;
(
    input  logic               lrom_en,
    input  logic               urom_en,
    output logic [NQ*SRC_W-1:0] rd_src,
    output logic [NQ*SRC_W-1:0] wr_src
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        if (q == 0) begin : g_lo
            // Lowest quarter: lower ROM overlay
            assign rd_src[q*SRC_W +: SRC_W] = lrom_en ? SRC_LROM : SRC_RAM;
        end else if (q == NQ-1) begin : g_hi
            // Highest quarter: upper ROM overlay
            assign rd_src[q*SRC_W +: SRC_W] = urom_en ? SRC_UROM : SRC_RAM;
        end else begin : g_mid
            // Middle quarters always read RAM
            assign rd_src[q*SRC_W +: SRC_W] = SRC_RAM;
        end
        // Writes never see the overlay
        assign wr_src[q*SRC_W +: SRC_W] = SRC_RAM;
    end
endmodule

// File: rtl/io_page_decoder.sv
// Top level: gate-array register file, partial port decoder, memory map
// and read-data return mux. Assumes one-clock I/O cycles.
module io_page_decoder
    import io_page_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  crtc_rdata,
    input  logic [7:0]  ppi_rdata,
    output logic [7:0]  io_rdata,
    output logic        ga_we,
    output logic        pen_we,
    output logic        colour_we,
    output logic [4:0]  pen,
    output logic [4:0]  colour,
    output logic [1:0]  scr_mode,
    output logic        lrom_en,
    output logic        urom_en,
    output logic [5:0]  ram_cfg,
    output logic        crtc_sel_we,
    output logic        crtc_reg_we,
    output logic        crtc_stat_re,
    output logic        crtc_reg_re,
    output logic        crtc_illegal,
    output logic        ppi_cs,
    output logic [1:0]  ppi_port,
    output logic        ppi_we,
    output logic        ppi_re,
    output logic [7:0]  rd_src,
    output logic [7:0]  wr_src
);
    localparam int GA_HI = ADDR_W - 1;

    logic ga_hit, crtc_rd_ok, ppi_rd_hit;
    logic unused_addr;

    assign unused_addr = ^{io_addr[7:0], io_addr[13:12], io_addr[10]};
    assign ga_hit = io_wr && (io_addr[GA_HI -: 2] == 2'b01);

    ga_regs u_ga (
        .clk(clk), .rst_n(rst_n), .hit(ga_hit), .wdata(io_wdata),
        .ga_we(ga_we), .pen_we(pen_we), .colour_we(colour_we),
        .pen(pen), .colour(colour), .scr_mode(scr_mode),
        .lrom_en(lrom_en), .urom_en(urom_en), .ram_cfg(ram_cfg)
    );

    port_decode u_pd (
        .clk(clk), .rst_n(rst_n), .crtc_n(io_addr[14]), .ppi_n(io_addr[11]),
        .fn(io_addr[9:8]), .io_wr(io_wr), .io_rd(io_rd),
        .crtc_rd_ok(crtc_rd_ok), .ppi_rd_hit(ppi_rd_hit),
        .crtc_sel_we(crtc_sel_we), .crtc_reg_we(crtc_reg_we),
        .crtc_stat_re(crtc_stat_re), .crtc_reg_re(crtc_reg_re),
        .crtc_illegal(crtc_illegal), .ppi_cs(ppi_cs), .ppi_port(ppi_port),
        .ppi_we(ppi_we), .ppi_re(ppi_re)
    );

    mem_map u_mm (
        .lrom_en(lrom_en), .urom_en(urom_en), .rd_src(rd_src), .wr_src(wr_src)
    );

    // Return data: AND of the addressed readable sources, 0xFF when none
    always_comb begin
        io_rdata = '1;
        if (crtc_rd_ok) io_rdata = io_rdata & crtc_rdata;
        if (ppi_rd_hit) io_rdata = io_rdata & ppi_rdata;
    end

    // R1
    ga_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ga_we |-> $past(io_wr) && $past(io_addr[15:14]) == 2'b01);
endmodule

// File: tb/sim_io_page_decoder.sv
module sim_io_page_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  crtc_rdata = 8'hF0, ppi_rdata = 8'h3C;
    logic [7:0]  io_rdata;
    logic        ga_we, pen_we, colour_we;
    logic [4:0]  pen, colour;
    logic [1:0]  scr_mode;
    logic        lrom_en, urom_en;
    logic [5:0]  ram_cfg;
    logic        crtc_sel_we, crtc_reg_we, crtc_stat_re, crtc_reg_re, crtc_illegal;
    logic        ppi_cs, ppi_we, ppi_re;
    logic [1:0]  ppi_port;
    logic [7:0]  rd_src, wr_src;

    int vectors = 0, miscompares = 0;

    always #5 clk = ~clk;

    io_page_decoder u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // strobe bundle: {ga,pen,col,csel,creg,cstat,crd,cill,pcs,pwe,pre}
    function automatic logic [10:0] strobes();
        return {ga_we, pen_we, colour_we, crtc_sel_we, crtc_reg_we, crtc_stat_re,
                crtc_reg_re, crtc_illegal, ppi_cs, ppi_we, ppi_re};
    endfunction

    // Write one cycle; returns at the negedge where strobes are visible
    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    // Read one cycle; rdata sampled mid-cycle, returns with strobes visible
    task automatic io_read(logic [15:0] a, output logic [7:0] rd);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #1 rd = io_rdata;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 regs", {pen, colour, scr_mode, ram_cfg}, 0);
        chk("R10 rom", {lrom_en, urom_en}, 2'b11);
        chk("R10 rd_src", rd_src, 8'h81);
        chk("R10 strobes", strobes(), 0);
        chk("R9 wr_src", wr_src, 0);
    endtask

    task automatic t_pen_colour();
        io_write(16'h7F00, 8'h3D);
        chk("R2 strobes", strobes(), 11'b110_0000_0000);
        chk("R2 pen", pen, 5'h1D);
        @(negedge clk);
        chk("R12 pulse ends", strobes(), 0);
        io_write(16'h7F00, 8'h52);
        chk("R3 strobes", strobes(), 11'b101_0000_0000);
        chk("R3 colour", colour, 5'h12);
        chk("R3 pen kept", pen, 5'h1D);
        @(negedge clk);
    endtask

    task automatic t_mode_rom();
        io_write(16'h7F00, 8'h86);
        chk("R4 mode", scr_mode, 2);
        chk("R4/R9 lower off", rd_src, 8'h80);
        chk("R1 ga_we", ga_we, 1);
        io_write(16'h7F00, 8'h89);
        chk("R4 mode1", scr_mode, 1);
        chk("R4/R9 upper off", rd_src, 8'h01);
        io_write(16'h7F00, 8'h8C);
        chk("R9 both off", rd_src, 8'h00);
        chk("R9 wr_src", wr_src, 0);
        io_write(16'h7F00, 8'h80);
        chk("R9 both on", rd_src, 8'h81);
        @(negedge clk);
    endtask

    task automatic t_ramcfg();
        io_write(16'h7F00, 8'hFF);
        chk("R5 ram_cfg", ram_cfg, 6'h3F);
        chk("R5 no map change", rd_src, 8'h81);
        chk("R5 regs kept", {pen, colour, scr_mode}, {5'h1D, 5'h12, 2'd0});
        chk("R5 no pen/colour strobe", {pen_we, colour_we}, 0);
        @(negedge clk);
    endtask

    task automatic t_crtc();
        logic [7:0] rd;
        io_write(16'hBC00, 8'h0C);
        chk("R6 select", strobes(), 11'b000_1000_0000);
        io_write(16'hBD00, 8'h30);
        chk("R6 data wr", strobes(), 11'b000_0100_0000);
        io_read(16'hBE00, rd);
        chk("R6 status rd", strobes(), 11'b000_0010_0000);
        chk("R11 crtc data", rd, 8'hF0);
        io_read(16'hBF00, rd);
        chk("R6 reg rd", strobes(), 11'b000_0001_0000);
        @(negedge clk);
        chk("R12 pulse ends", strobes(), 0);
    endtask

    task automatic t_illegal();
        logic [7:0] rd;
        io_write(16'hBE00, 8'h11);
        chk("R7 wr fn10", strobes(), 11'b000_0000_1000);
        io_write(16'hBF00, 8'h11);
        chk("R7 wr fn11", strobes(), 11'b000_0000_1000);
        io_read(16'hBC00, rd);
        chk("R7 rd fn00", strobes(), 11'b000_0000_1000);
        chk("R11 illegal rd ff", rd, 8'hFF);
        io_read(16'hBD00, rd);
        chk("R7 rd fn01", strobes(), 11'b000_0000_1000);
        @(negedge clk);
    endtask

    task automatic t_ppi();
        logic [7:0] rd;
        for (int p = 0; p < 4; p++) begin
            io_write(16'hF400 | (16'(p) << 8), 8'h55);
            chk("R8 wr", {strobes(), ppi_port}, {11'b000_0000_0110, 2'(p)});
        end
        io_read(16'hF500, rd);
        chk("R8 rd", {strobes(), ppi_port}, {11'b000_0000_0101, 2'd1});
        chk("R11 ppi data", rd, 8'h3C);
        io_read(16'h7F00, rd);
        chk("R11 nothing readable", rd, 8'hFF);
        chk("R11 no strobes", strobes(), 0);
        @(negedge clk);
    endtask

    task automatic t_overlap();
        logic [7:0] rd;
        io_write(16'h7400, 8'h07);
        chk("R12 ga+ppi", {strobes(), ppi_port}, {11'b110_0000_0110, 2'd0});
        chk("R12 pen", pen, 5'h07);
        io_read(16'h3600, rd);
        chk("R12 crtc+ppi", {strobes(), ppi_port}, {11'b000_0010_0101, 2'd2});
        chk("R11 AND", rd, 8'h30);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pen_colour();
        t_mode_rom();
        t_ramcfg();
        t_crtc();
        t_illegal();
        t_ppi();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule